// File: doc/BRIEF.md
# Hybrid Update/Invalidate Coherence Directory

This block is the coherence directory for one memory-bank slice. For every cache line in the slice it records which private caches hold a copy. Read and write requests come in on a direct request port. Coherence commands leave on a separate coherence port, so coherence traffic never shares a channel with ordinary data traffic. Each command is acknowledged on that same port.

A line that only a few caches share is kept coherent by updates. On a write, each recorded sharer except the writer gets its own update message. When one more cache joins a line whose list of sharer ids is already full, the line moves to broadcast mode and stops recording ids. The next write to a broadcast-mode line sends a single broadcast invalidate and waits for one acknowledgement from every other cache. The line then goes back to update mode with the writer as its only sharer.

The controller handles one request at a time. A write is answered only after every acknowledgement it is owed has arrived.

Top module: `hyb_dir_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `coh_valid` are 0, and every line holds no sharers.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the response. A read is answered by a one-cycle `rsp_valid` pulse two cycles after acceptance, with `rsp_write`=0 and `rsp_src`/`rsp_line` echoing the request.
- R3: A write to an update-mode line sends one message (`coh_bcast`=0, `coh_line` = the line) for each recorded sharer other than the writer. The messages go out on consecutive cycles starting three cycles after acceptance, in the order the sharers were first recorded, and no other coherence message is sent.
- R4: The writing cache never receives an update for its own write.
- R5: A line records up to THRESHOLD distinct sharer ids. A read by a cache that is already recorded changes nothing.
- R6: A read or write by a new cache when THRESHOLD ids are already recorded puts the line in broadcast mode. After that, reads record nothing.
- R7: A write to a broadcast-mode line sends exactly one message with `coh_bcast`=1, two cycles after acceptance. `coh_dest` carries the writer, which is the one cache exempt from the invalidate. The write then waits for NUM_CACHES-1 acknowledgements.
- R8: After a broadcast write, the line is in update mode with the writer as its only sharer.
- R9: A write that sends coherence messages gives its response (`rsp_write`=1) in the cycle after the cycle in which the last owed `coh_ack` pulse is sampled, and never earlier.
- R10: A write to a line with no other recorded sharer sends no coherence message and is answered two cycles after acceptance. The writer is then recorded as a sharer.
- R11: Lines are tracked independently. Requests to one line never change what is recorded for another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_line | input | $clog2(LINES) | Line index within the slice |
| req_src | input | $clog2(NUM_CACHES) | Requesting cache id |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_write | output | 1 | Response belongs to a write |
| rsp_src | output | $clog2(NUM_CACHES) | Cache being answered |
| rsp_line | output | $clog2(LINES) | Line being answered |
| coh_valid | output | 1 | One-cycle coherence message pulse |
| coh_bcast | output | 1 | 1 = broadcast invalidate, 0 = targeted update |
| coh_dest | output | $clog2(NUM_CACHES) | Update target, or the exempt writer for a broadcast |
| coh_line | output | $clog2(LINES) | Line the message concerns |
| coh_ack | input | 1 | One acknowledgement per pulse |

## Verification
Counting from the accepting edge, these results are due at fixed times:

- A read response, and the response to a write with no other sharers, is due in the second cycle.
- A broadcast invalidate is due in the second cycle.
- Targeted updates are due from the third cycle on, one per cycle.
- A write response is due in the cycle right after the final acknowledgement is sampled.

The bench drives inputs and samples outputs on falling edges. At each falling edge it compares `rsp_valid` and `coh_valid` with the value the queue-based model expects for that exact cycle, so both early and late outputs are caught. It spaces acknowledgements by 0 to 3 idle cycles, which shows that the response waits for the count of acknowledgements rather than a fixed delay.

// File: rtl/hdir_pkg.sv
`timescale 1ns/1ps
package hdir_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_SEND,
    ST_WAIT
  } ctl_st_t;
endpackage

// File: rtl/hdir_store.sv
`timescale 1ns/1ps
// Directory entry storage: RAM-style array with a synchronous read,
// plus a resettable per-line valid vector so that lines start out empty.
module hdir_store #(
  parameter int LINES = 16,
  parameter int EW    = 8,
  localparam int LW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [LW-1:0] rd_idx,
  output logic [EW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [LW-1:0] wr_idx,
  input  logic [EW-1:0] wr_data
);
  logic [EW-1:0]    mem [LINES];
  logic [EW-1:0]    rd_q;
  logic [LINES-1:0] vld;
  logic             hit_q;

  // no reset on the array, so it can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      hit_q <= 1'b0;
    end else begin
      if (wr_en) vld[wr_idx] <= 1'b1;
      if (rd_en) hit_q <= vld[rd_idx];
    end
  end

  // a line never written reads as an empty entry
  assign rd_data = hit_q ? rd_q : '0;
endmodule

// File: rtl/hdir_calc.sv
`timescale 1ns/1ps
// Combinational sharer bookkeeping for one entry: which slots need an
// update, how many, and the entry after the requester is added.
module hdir_calc #(
  parameter int NUM_CACHES = 8,
  parameter int THRESHOLD  = 2,
  localparam int CW   = $clog2(NUM_CACHES),
  localparam int CNTW = $clog2(THRESHOLD + 1),
  localparam int ACKW = $clog2(NUM_CACHES + 1)
) (
  input  logic [THRESHOLD*CW-1:0] ids,
  input  logic [CNTW-1:0]         cnt,
  input  logic                    bc,
  input  logic [CW-1:0]           src,
  output logic [THRESHOLD-1:0]    send_mask,
  output logic [ACKW-1:0]         send_n,
  output logic [THRESHOLD*CW-1:0] new_ids,
  output logic [CNTW-1:0]         new_cnt,
  output logic                    new_bc
);
  logic [THRESHOLD-1:0] match;
  logic                 present;
  logic                 add_here;

  assign present  = |match;
  assign add_here = !bc && !present;

  for (genvar s = 0; s < THRESHOLD; s++) begin : g_slot
    logic slot_used;
    assign slot_used    = CNTW'(s) < cnt;
    assign match[s]     = slot_used && (ids[s*CW +: CW] == src);
    assign send_mask[s] = slot_used && !match[s];
    assign new_ids[s*CW +: CW] = (add_here && cnt == CNTW'(s)) ? src : ids[s*CW +: CW];
  end

  assign new_cnt = (add_here && cnt < CNTW'(THRESHOLD)) ? cnt + 1'b1 : cnt;
  assign new_bc  = bc || (!present && cnt == CNTW'(THRESHOLD));

  always_comb begin
    send_n = '0;
    for (int s = 0; s < THRESHOLD; s++) send_n = send_n + ACKW'(send_mask[s]);
  end
endmodule

// File: rtl/hdir_pick.sv
`timescale 1ns/1ps
// Lowest-index-first selection over the pending update slots.
module hdir_pick #(
  parameter int THRESHOLD = 2,
  localparam int SW = (THRESHOLD > 1) ? $clog2(THRESHOLD) : 1
) (
  input  logic [THRESHOLD-1:0] mask,
  output logic [SW-1:0]        idx,
  output logic                 found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int s = THRESHOLD - 1; s >= 0; s--) begin
      if (mask[s]) begin
        idx   = SW'(s);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hyb_dir_ctrl.sv
`timescale 1ns/1ps
module hyb_dir_ctrl
  import hdir_pkg::*;
#(
  parameter int NUM_CACHES = 8,
  parameter int LINES      = 16,
  parameter int THRESHOLD  = 2,
  localparam int CW   = $clog2(NUM_CACHES),
  localparam int LW   = $clog2(LINES),
  localparam int CNTW = $clog2(THRESHOLD + 1),
  localparam int ACKW = $clog2(NUM_CACHES + 1),
  localparam int IDW  = THRESHOLD * CW,
  localparam int EW   = IDW + CNTW + 1,
  localparam int SW   = (THRESHOLD > 1) ? $clog2(THRESHOLD) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [LW-1:0] req_line,
  input  logic [CW-1:0] req_src,
  output logic          rsp_valid,
  output logic          rsp_write,
  output logic [CW-1:0] rsp_src,
  output logic [LW-1:0] rsp_line,
  output logic          coh_valid,
  output logic          coh_bcast,
  output logic [CW-1:0] coh_dest,
  output logic [LW-1:0] coh_line,
  input  logic          coh_ack
);
  ctl_st_t              st;
  logic                 r_write;
  logic [LW-1:0]        r_line;
  logic [CW-1:0]        r_src;
  logic [THRESHOLD-1:0] pend;
  logic [IDW-1:0]       ids_q;
  logic [ACKW-1:0]      ack_need;
  logic [ACKW-1:0]      ack_got;
  logic [ACKW-1:0]      ack_sum;

  logic [EW-1:0]        rd_entry;
  logic [EW-1:0]        wr_entry;
  logic [IDW-1:0]       e_ids;
  logic [CNTW-1:0]      e_cnt;
  logic                 e_bc;
  logic [THRESHOLD-1:0] send_mask;
  logic [ACKW-1:0]      send_n;
  logic [IDW-1:0]       n_ids;
  logic [CNTW-1:0]      n_cnt;
  logic                 n_bc;
  logic [SW-1:0]        pick;
  logic                 pick_ok;
  logic                 accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  assign e_ids = rd_entry[IDW-1:0];
  assign e_cnt = rd_entry[IDW +: CNTW];
  assign e_bc  = rd_entry[EW-1];

  // a broadcast write leaves only the writer; otherwise add the requester
  assign wr_entry = (r_write && e_bc) ? {1'b0, CNTW'(1), IDW'(r_src)}
                                      : {n_bc, n_cnt, n_ids};
  assign ack_sum  = ack_got + ACKW'(coh_ack);

  hdir_store #(.LINES(LINES), .EW(EW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (accept),
    .rd_idx  (req_line),
    .rd_data (rd_entry),
    .wr_en   (st == ST_LOOK),
    .wr_idx  (r_line),
    .wr_data (wr_entry)
  );

  hdir_calc #(.NUM_CACHES(NUM_CACHES), .THRESHOLD(THRESHOLD)) u_calc (
    .ids       (e_ids),
    .cnt       (e_cnt),
    .bc        (e_bc),
    .src       (r_src),
    .send_mask (send_mask),
    .send_n    (send_n),
    .new_ids   (n_ids),
    .new_cnt   (n_cnt),
    .new_bc    (n_bc)
  );

  hdir_pick #(.THRESHOLD(THRESHOLD)) u_pick (
    .mask  (pend),
    .idx   (pick),
    .found (pick_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      r_write   <= 1'b0;
      r_line    <= '0;
      r_src     <= '0;
      pend      <= '0;
      ids_q     <= '0;
      ack_need  <= '0;
      ack_got   <= '0;
      rsp_valid <= 1'b0;
      rsp_write <= 1'b0;
      rsp_src   <= '0;
      rsp_line  <= '0;
      coh_valid <= 1'b0;
      coh_bcast <= 1'b0;
      coh_dest  <= '0;
      coh_line  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      coh_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            r_write <= req_write;
            r_line  <= req_line;
            r_src   <= req_src;
            ack_got <= '0;
            st      <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          ids_q <= e_ids;
          if (!r_write || (!e_bc && send_n == '0)) begin
            rsp_valid <= 1'b1;
            rsp_write <= r_write;
            rsp_src   <= r_src;
            rsp_line  <= r_line;
            st        <= ST_IDLE;
          end else if (e_bc) begin
            coh_valid <= 1'b1;
            coh_bcast <= 1'b1;
            coh_dest  <= r_src;
            coh_line  <= r_line;
            ack_need  <= ACKW'(NUM_CACHES - 1);
            st        <= ST_WAIT;
          end else begin
            pend     <= send_mask;
            ack_need <= send_n;
            st       <= ST_SEND;
          end
        end
        ST_SEND: begin
          ack_got <= ack_sum;
          if (pick_ok) begin
            coh_valid <= 1'b1;
            coh_bcast <= 1'b0;
            coh_dest  <= ids_q[pick*CW +: CW];
            coh_line  <= r_line;
          end
          pend <= pend & ~(THRESHOLD'(1) << pick);
          if ((pend & ~(THRESHOLD'(1) << pick)) == '0) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (ack_sum >= ack_need) begin
            rsp_valid <= 1'b1;
            rsp_write <= r_write;
            rsp_src   <= r_src;
            rsp_line  <= r_line;
            st        <= ST_IDLE;
          end else begin
            ack_got <= ack_sum;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_rsp_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_no_self_update_R4: assert property (@(posedge clk) disable iff (rst)
    (coh_valid && !coh_bcast) |-> (coh_dest != r_src));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK) |-> (e_cnt <= CNTW'(THRESHOLD)));

  assert_single_bcast_R7: assert property (@(posedge clk) disable iff (rst)
    (coh_valid && coh_bcast) |=> !coh_valid);

  assert_ack_not_exceeded_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> (ack_got < ack_need));

  assert_no_rsp_with_coh_R9: assert property (@(posedge clk) disable iff (rst)
    coh_valid |-> !rsp_valid);
endmodule

// File: tb/sim_hyb_dir_ctrl.sv
`timescale 1ns/1ps
module sim_hyb_dir_ctrl;
  localparam int NC    = 8;
  localparam int NL    = 16;
  localparam int TH    = 2;
  localparam int CW    = $clog2(NC);
  localparam int LW    = $clog2(NL);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [LW-1:0] req_line = '0;
  logic [CW-1:0] req_src = '0;
  logic          rsp_valid, rsp_write;
  logic [CW-1:0] rsp_src;
  logic [LW-1:0] rsp_line;
  logic          coh_valid, coh_bcast;
  logic [CW-1:0] coh_dest;
  logic [LW-1:0] coh_line;
  logic          coh_ack = 1'b0;

  int total = 0;
  int bad   = 0;

  // behavioural model: per line, ordered list of sharer ids and a mode bit
  int m_ids [NL][$];
  bit m_bc  [NL];

  always #2.5 clk = ~clk;

  hyb_dir_ctrl #(.NUM_CACHES(NC), .LINES(NL), .THRESHOLD(TH)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_line(req_line), .req_src(req_src),
    .rsp_valid(rsp_valid), .rsp_write(rsp_write), .rsp_src(rsp_src), .rsp_line(rsp_line),
    .coh_valid(coh_valid), .coh_bcast(coh_bcast), .coh_dest(coh_dest), .coh_line(coh_line),
    .coh_ack(coh_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_add(input int line, input int src);
    bit found = 0;
    if (m_bc[line]) return;
    foreach (m_ids[line][i]) if (m_ids[line][i] == src) found = 1;
    if (found) return;
    if (m_ids[line].size() < TH) m_ids[line].push_back(src);
    else m_bc[line] = 1;
  endfunction

  task automatic do_req(input bit w, input int line, input int src, input int gap);
    int tg[$];
    bit bexp;
    int nack;
    bexp = w && m_bc[line];
    if (w && !bexp) foreach (m_ids[line][i]) if (m_ids[line][i] != src) tg.push_back(m_ids[line][i]);

    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_write = w; req_line = LW'(line); req_src = CW'(src);
    @(posedge clk);
    @(negedge clk);                                   // +1
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    chk(!rsp_valid && !coh_valid, "R2 nothing at +1", rsp_valid + 2*coh_valid, 0);
    @(negedge clk);                                   // +2
    if (!bexp && tg.size() == 0) begin
      chk(rsp_valid == 1'b1, w ? "R10 direct write response" : "R2 read response", rsp_valid, 1);
      chk(rsp_write == w && rsp_src == CW'(src) && rsp_line == LW'(line),
          "R2 response fields", {rsp_write, rsp_src, rsp_line}, {w, CW'(src), LW'(line)});
      chk(coh_valid == 1'b0, "R10 no coherence traffic", coh_valid, 0);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2 response is one cycle", rsp_valid, 0);
    end else begin
      if (bexp) begin
        chk(coh_valid && coh_bcast, "R7 broadcast at +2", {coh_valid, coh_bcast}, 3);
        chk(coh_dest == CW'(src) && coh_line == LW'(line), "R7 broadcast fields", coh_dest, src);
        nack = NC - 1;
      end else begin
        chk(coh_valid == 1'b0, "R3 no update at +2", coh_valid, 0);
        foreach (tg[i]) begin
          @(negedge clk);
          chk(coh_valid && !coh_bcast, "R3 update message", {coh_valid, coh_bcast}, 2);
          chk(coh_dest == CW'(tg[i]), "R4 update target", coh_dest, tg[i]);
          chk(coh_line == LW'(line), "R3 update line", coh_line, line);
          chk(rsp_valid == 1'b0, "R9 no early response", rsp_valid, 0);
        end
        nack = tg.size();
      end
      for (int k = 0; k < nack; k++) begin
        coh_ack = 1'b1;
        @(negedge clk);
        coh_ack = 1'b0;
        chk(coh_valid == 1'b0, "R3 no extra message", coh_valid, 0);
        if (k == nack - 1) begin
          chk(rsp_valid == 1'b1, "R9 response after last ack", rsp_valid, 1);
          chk(rsp_write == 1'b1 && rsp_src == CW'(src), "R9 write response fields", rsp_src, src);
        end else begin
          chk(rsp_valid == 1'b0, "R9 held until all acks", rsp_valid, 0);
          for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk(rsp_valid == 1'b0, "R9 held during ack gap", rsp_valid, 0);
          end
        end
      end
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R2 response is one cycle", rsp_valid, 0);
    end

    if (bexp) begin
      m_ids[line] = {};
      m_ids[line].push_back(src);
      m_bc[line] = 0;
    end else begin
      model_add(line, src);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0 && coh_valid == 1'b0, "R1 outputs quiet", rsp_valid + coh_valid, 0);

    do_req(1, 3, 5, 0);   // R1/R10: fresh line write, no traffic
    do_req(0, 3, 1, 0);   // R2: read adds sharer 1
    do_req(0, 3, 5, 0);   // R5: repeat reader, no change
    do_req(1, 3, 1, 1);   // R4: update only to 5
    do_req(1, 3, 6, 0);   // R3: updates 5 then 1; 6 overflows -> R6
    do_req(0, 3, 2, 0);   // R6: read in broadcast mode
    do_req(1, 3, 2, 2);   // R7/R9: broadcast, acks with gaps
    do_req(1, 3, 4, 0);   // R8: update only to previous writer 2
    do_req(1, 0, 7, 0);   // R11: untouched line 0 stays empty
    do_req(0, 15, 0, 0);  // R11: top line index
    do_req(0, 15, 7, 0);
    do_req(0, 15, 3, 0);  // R6: third sharer -> broadcast mode
    do_req(1, 15, 0, 3);  // R7/R9
    do_req(1, 3, 2, 3);   // R3/R9: line 3 unaffected by line 15, update to 4
    do_req(1, 15, 0, 0);  // R8: only writer recorded, direct response

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule